// File: doc/BRIEF.md
# Byte-Lane ECC Static Memory Core

This block is a clocked word memory with 16-bit data and active-low controls: a select, an output enable, a write strobe, and one enable for each byte lane. A power-gate qualifier must be high for any access. Each 8-bit lane is stored with its own four-bit single-error-correcting Hamming code. Because each lane carries its own code, a write to one byte never needs to read the other byte first.

Reads are registered and take one cycle. The data bus and the error flag are modelled as a value plus a drive-enable, not as true three-state pins. A lane that is not read drives zero with its enable low. The error flag rises when a read corrects a single flipped bit in any lane being read. The corrected word is never written back, so a flipped bit persists until that lane is written again.

A test-only inject port XORs a mask into a stored codeword. This lets a bench build single-bit faults at known positions.

Top module: `ecc_sram_core`

## Requirements
- R1: A write occurs at a rising edge when cs_n=0, we_n=0 and sleep_n=1. Lane 1 (wdata[15:8]) is written only if ub_n=0, and lane 0 (wdata[7:0]) only if lb_n=0. A lane whose enable is high keeps its stored value.
- R2: No lane is written when cs_n=1, when sleep_n=0, or when ub_n=lb_n=1.
- R3: A read is issued when cs_n=0, oe_n=0, we_n=1 and sleep_n=1. The data for addr appears on rdata after the next rising edge and holds until the edge after that.
- R4: After an edge, rdata_oe[1] is high only if that edge sampled a read with ub_n=0, and rdata_oe[0] likewise with lb_n=0. A lane whose rdata_oe bit is low reads as zero. When we_n=0, no lane is driven even if oe_n=0.
- R5: A single flipped bit in any of the 12 stored bits of a lane is corrected on read.
- R6: err_oe is high exactly when at least one lane is driven. err_flag is 1 only if a driven lane had a correction, and is 0 otherwise, including while err_oe is low.
- R7: A corrected read does not repair the array. Repeated reads keep raising err_flag until that lane is written again.
- R8: When inj_en=1, the stored codeword at inj_addr is XORed with inj_mask, and any functional write in that cycle is dropped. inj_mask[11:0] covers lane 0 and inj_mask[23:12] covers lane 1. Within a lane, bit k is Hamming position k+1, and positions 1, 2, 4 and 8 hold check bits.
- R9: After a reset cycle (rst=1), rdata_oe=0, err_oe=0, err_flag=0 and rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the read registers |
| cs_n | input | 1 | Select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| ub_n | input | 1 | Upper lane enable (bits 15:8), active low |
| lb_n | input | 1 | Lower lane enable (bits 7:0), active low |
| sleep_n | input | 1 | Power-gate qualifier; low blocks all access |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Corrected read data, zero in undriven lanes |
| rdata_oe | output | 2 | Per-lane drive enable (bit 1 upper, bit 0 lower) |
| err_flag | output | 1 | Correction indicator |
| err_oe | output | 1 | Drive enable of err_flag |
| inj_en | input | 1 | Test: apply fault mask |
| inj_addr | input | ADDR_W | Test: fault address |
| inj_mask | input | 24 | Test: XOR mask over both lane codewords |

## Verification
The bench builds the core with ADDR_W=4, which gives 16 words. At that size every address can be written and read under all four lane-enable combinations. Every one of the 24 stored bit positions can be flipped in turn, each followed by corrected reads, a read of the other lane alone, a repeat read and a repair write. The blocked write conditions are checked by reading the word back. The non-read controls are checked for undriven outputs in the cycle after they are applied.

// File: rtl/ecc_sram_pkg.sv
`timescale 1ns/1ps
package ecc_sram_pkg;
  localparam int LANE_W = 8;
  localparam int CHK_W  = 4;
  localparam int CW_W   = LANE_W + CHK_W;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;
  localparam int MASK_W = CW_W * LANES;

  // position p (1-based) is a check bit when p is a power of two
  function automatic logic is_chk_pos(input int pos);
    return (pos & (pos - 1)) == 0;
  endfunction

  function automatic logic [CW_W-1:0] ham_encode(input logic [LANE_W-1:0] d);
    logic [CW_W-1:0] cw;
    int k;
    cw = '0;
    k  = 0;
    for (int pos = 1; pos <= CW_W; pos++) begin
      if (!is_chk_pos(pos)) begin
        cw[pos-1] = d[k];
        k++;
      end
    end
    for (int p = 0; p < CHK_W; p++) begin
      logic par;
      par = 1'b0;
      for (int pos = 1; pos <= CW_W; pos++)
        if ((((pos >> p) & 1) == 1) && !is_chk_pos(pos)) par ^= cw[pos-1];
      cw[(1 << p) - 1] = par;
    end
    return cw;
  endfunction

  function automatic logic [CHK_W-1:0] ham_syndrome(input logic [CW_W-1:0] cw);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int pos = 1; pos <= CW_W; pos++)
      if (cw[pos-1]) s ^= CHK_W'(pos);
    return s;
  endfunction

  function automatic logic [LANE_W-1:0] ham_extract(input logic [CW_W-1:0] cw);
    logic [LANE_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int pos = 1; pos <= CW_W; pos++) begin
      if (!is_chk_pos(pos)) begin
        d[k] = cw[pos-1];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/ecc_sram_ctrl.sv
`timescale 1ns/1ps
module ecc_sram_ctrl
  import ecc_sram_pkg::*;
(
  input  logic             cs_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic             ub_n,
  input  logic             lb_n,
  input  logic             sleep_n,
  output logic [LANES-1:0] wr_lane,
  output logic [LANES-1:0] rd_lane
);
  logic             access;
  logic [LANES-1:0] lane_sel;

  assign access   = !cs_n && sleep_n;
  assign lane_sel = ~{ub_n, lb_n};

  always_comb begin
    wr_lane = '0;
    rd_lane = '0;
    if (access && !we_n)          wr_lane = lane_sel;
    else if (access && !oe_n)     rd_lane = lane_sel;
  end
endmodule

// File: rtl/ecc_sram_lane.sv
`timescale 1ns/1ps
module ecc_sram_lane
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [CW_W-1:0]   inj_mask,
  output logic [LANE_W-1:0] rdata,
  output logic              drive,
  output logic              corr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CW_W-1:0]  mem [DEPTH];
  logic [CW_W-1:0]  wr_cw;
  logic [CW_W-1:0]  cw_q;
  logic [CW_W-1:0]  fixed_cw;
  logic [CHK_W-1:0] syn;
  logic             rd_q;

  assign wr_cw = ham_encode(wdata);

  // single write port: fault injection wins over a functional write
  always_ff @(posedge clk) begin
    if (inj_en)     mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
    else if (wr_en) mem[addr]     <= wr_cw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      cw_q <= '0;
    end else begin
      rd_q <= rd_en;
      if (rd_en) cw_q <= mem[addr];
    end
  end

  always_comb begin
    syn      = ham_syndrome(cw_q);
    fixed_cw = cw_q;
    for (int pos = 1; pos <= CW_W; pos++)
      if (syn == CHK_W'(pos)) fixed_cw[pos-1] = ~cw_q[pos-1];
  end

  assign rdata = rd_q ? ham_extract(fixed_cw) : '0;
  assign drive = rd_q;
  assign corr  = rd_q && (syn != '0);
endmodule

// File: rtl/ecc_sram_core.sv
`timescale 1ns/1ps
module ecc_sram_core
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic              sleep_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic [1:0]        rdata_oe,
  output logic              err_flag,
  output logic              err_oe,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [23:0]       inj_mask
);
  logic [LANES-1:0] wr_lane;
  logic [LANES-1:0] rd_lane;
  logic [LANES-1:0] lane_drive;
  logic [LANES-1:0] lane_corr;

  ecc_sram_ctrl u_ctrl (
    .cs_n    (cs_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .ub_n    (ub_n),
    .lb_n    (lb_n),
    .sleep_n (sleep_n),
    .wr_lane (wr_lane),
    .rd_lane (rd_lane)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ecc_sram_lane #(.ADDR_W(ADDR_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .addr     (addr),
      .wr_en    (wr_lane[l]),
      .wdata    (wdata[l*LANE_W +: LANE_W]),
      .rd_en    (rd_lane[l]),
      .inj_en   (inj_en),
      .inj_addr (inj_addr),
      .inj_mask (inj_mask[l*CW_W +: CW_W]),
      .rdata    (rdata[l*LANE_W +: LANE_W]),
      .drive    (lane_drive[l]),
      .corr     (lane_corr[l])
    );
  end

  assign rdata_oe = lane_drive;
  assign err_oe   = |lane_drive;
  assign err_flag = |lane_corr;
endmodule

// File: rtl/ecc_sram_chk.sv
`timescale 1ns/1ps
module ecc_sram_chk (
  input logic        clk,
  input logic        rst,
  input logic        cs_n,
  input logic        oe_n,
  input logic        we_n,
  input logic        ub_n,
  input logic        lb_n,
  input logic        sleep_n,
  input logic [15:0] rdata,
  input logic [1:0]  rdata_oe,
  input logic        err_flag,
  input logic        err_oe
);
  // R4
  idle_undriven_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n || oe_n || !we_n || !sleep_n) |=> (rdata_oe == 2'b00 && !err_oe));

  // R3
  full_read_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !oe_n && we_n && sleep_n && !ub_n && !lb_n) |=> (rdata_oe == 2'b11 && err_oe));

  // R4
  low_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rdata_oe[0] |-> (rdata[7:0] == 8'h00));

  // R4
  high_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rdata_oe[1] |-> (rdata[15:8] == 8'h00));

  // R6
  flag_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !err_oe |-> !err_flag);

  // R9
  post_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rdata_oe == 2'b00 && !err_oe && !err_flag));
endmodule

bind ecc_sram_core ecc_sram_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .oe_n     (oe_n),
  .we_n     (we_n),
  .ub_n     (ub_n),
  .lb_n     (lb_n),
  .sleep_n  (sleep_n),
  .rdata    (rdata),
  .rdata_oe (rdata_oe),
  .err_flag (err_flag),
  .err_oe   (err_oe)
);

// File: tb/tb_ecc_sram_core.sv
`timescale 1ns/1ps
module tb_ecc_sram_core;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1, sleep_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [1:0]    rdata_oe;
  logic          err_flag, err_oe;
  logic          inj_en = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [23:0]   inj_mask = '0;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] model [DEPTH];
  logic [1:0]  errl  [DEPTH];

  always #2.5 clk = ~clk;

  ecc_sram_core #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .ub_n(ub_n), .lb_n(lb_n), .sleep_n(sleep_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe), .err_flag(err_flag), .err_oe(err_oe),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic c, input logic o, input logic w, input logic u,
                       input logic l, input logic s, input logic [AW-1:0] a,
                       input logic [15:0] d, input logic ij, input logic [AW-1:0] ia,
                       input logic [23:0] im);
    @(negedge clk);
    cs_n = c; oe_n = o; we_n = w; ub_n = u; lb_n = l; sleep_n = s;
    addr = a; wdata = d; inj_en = ij; inj_addr = ia; inj_mask = im;
    @(posedge clk);
    #1;
  endtask

  task automatic model_wr(input logic c, input logic u, input logic l, input logic s,
                          input logic [AW-1:0] a, input logic [15:0] d);
    if (!c && s) begin
      if (!u) begin model[a][15:8] = d[15:8]; errl[a][1] = 1'b0; end
      if (!l) begin model[a][7:0]  = d[7:0];  errl[a][0] = 1'b0; end
    end
  endtask

  // write strobe with oe_n high
  task automatic wr(input logic c, input logic u, input logic l, input logic s,
                    input logic [AW-1:0] a, input logic [15:0] d);
    cycle(c, 1'b1, 1'b0, u, l, s, a, d, 1'b0, '0, '0);
    model_wr(c, u, l, s, a, d);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic u, input logic l, input string tag);
    logic [1:0]  en;
    logic [15:0] ed;
    en = ~{u, l};
    ed = {en[1] ? model[a][15:8] : 8'h00, en[0] ? model[a][7:0] : 8'h00};
    cycle(1'b0, 1'b0, 1'b1, u, l, 1'b1, a, 16'h0, 1'b0, '0, '0);
    chk({tag, " data"},   32'(rdata),    32'(ed));
    chk({tag, " drive"},  32'(rdata_oe), 32'(en));
    chk({tag, " erroe"},  32'(err_oe),   32'(|en));
    chk({tag, " errflg"}, 32'(err_flag), 32'(|(en & errl[a])));
  endtask

  task automatic off_chk(input string tag);
    chk({tag, " drive"}, 32'(rdata_oe), 32'h0);
    chk({tag, " erroe"}, 32'(err_oe),   32'h0);
    chk({tag, " errflg"}, 32'(err_flag), 32'h0);
    chk({tag, " data"},  32'(rdata),    32'h0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin model[i] = '0; errl[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    off_chk("R9 reset");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    off_chk("R9 after release");

    // R1 full-word writes, R3/R4 reads with every lane combination
    for (int a = 0; a < DEPTH; a++)
      wr(1'b0, 1'b0, 1'b0, 1'b1, AW'(a), 16'(a * 16'h1357) ^ 16'hA5C3);
    for (int a = 0; a < DEPTH; a++)
      for (int m = 0; m < 4; m++)
        rd_chk(AW'(a), m[1], m[0], "R3 R4 sweep");

    // R1 byte-lane writes
    for (int a = 0; a < DEPTH; a++) begin
      wr(1'b0, 1'b0, 1'b1, 1'b1, AW'(a), 16'(a * 16'h0F0F) ^ 16'h5A00);
      rd_chk(AW'(a), 1'b0, 1'b0, "R1 upper lane write");
      wr(1'b0, 1'b1, 1'b0, 1'b1, AW'(a), 16'(a * 16'h0101) ^ 16'h00C6);
      rd_chk(AW'(a), 1'b0, 1'b0, "R1 lower lane write");
    end

    // R2 blocked writes, then read back
    wr(1'b0, 1'b0, 1'b0, 1'b0, AW'(3), 16'hDEAD);
    rd_chk(AW'(3), 1'b0, 1'b0, "R2 sleep blocks write");
    wr(1'b1, 1'b0, 1'b0, 1'b1, AW'(4), 16'hBEEF);
    rd_chk(AW'(4), 1'b0, 1'b0, "R2 deselect blocks write");
    wr(1'b0, 1'b1, 1'b1, 1'b1, AW'(5), 16'hCAFE);
    rd_chk(AW'(5), 1'b0, 1'b0, "R2 no lanes blocks write");

    // R4 non-read conditions leave outputs undriven
    cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, AW'(6), 16'h0, 1'b0, '0, '0);
    off_chk("R4 oe high");
    cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, AW'(6), 16'h0, 1'b0, '0, '0);
    off_chk("R4 deselected");
    cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, AW'(6), 16'h0, 1'b0, '0, '0);
    off_chk("R4 sleep");
    cycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, AW'(6), 16'h0, 1'b0, '0, '0);
    off_chk("R4 no lanes");
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, AW'(6), 16'h7E81, 1'b0, '0, '0);
    model_wr(1'b0, 1'b0, 1'b0, 1'b1, AW'(6), 16'h7E81);
    off_chk("R4 write with oe low");
    rd_chk(AW'(6), 1'b0, 1'b0, "R1 write with oe low");

    // R5 R6 R7 R8 every stored bit position
    for (int b = 0; b < 24; b++) begin
      logic [AW-1:0] a;
      a = AW'(b);
      cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, 16'h0, 1'b1, a, 24'(1) << b);
      errl[a][b / 12] = 1'b1;
      rd_chk(a, 1'b0, 1'b0, "R5 R6 corrected read");
      if (b < 12) rd_chk(a, 1'b0, 1'b1, "R6 other lane only");
      else        rd_chk(a, 1'b1, 1'b0, "R6 other lane only");
      rd_chk(a, 1'b0, 1'b0, "R7 repeat read keeps flag");
      wr(1'b0, 1'b0, 1'b0, 1'b1, a, 16'(b * 16'h0A0B) ^ 16'h3C96);
      rd_chk(a, 1'b0, 1'b0, "R7 rewrite clears flag");
    end

    // R8 inject wins over a same-cycle functional write
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, AW'(9), 16'h1234, 1'b1, AW'(9), 24'h000004);
    errl[9][0] = 1'b1;
    rd_chk(AW'(9), 1'b0, 1'b0, "R8 write dropped during inject");

    cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, 16'h0, 1'b0, '0, '0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule